// File: doc/BRIEF.md
# Fixed-Block Near-Memory Sum Reducer

This block sits beside a memory and answers one kind of command: given a byte address, it adds 32 consecutive 64-bit words starting there and returns the single 64-bit total. The command holds only the address and a tag. The operation and the block size are fixed, so there is no length or opcode field. The host therefore receives one small response in place of 32 word reads.

Internally the block fetches the 32 words as four line reads of eight words each. It gathers two lines (16 words) into a pass buffer and reduces them with a 16-input adder tree. A pass accumulator adds the two partial sums. The memory port is a simple request/response interface. The requester presents a byte address. The memory accepts it with a ready signal and returns the eight consecutive words later, as a one-cycle valid pulse. Any number of stall cycles may occur on either side.

Top module: `sumred_top`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: An accepted command with an 8-byte-aligned address returns the sum of the 32 quadwords at byte addresses `cmd_addr + 8*i`, for i = 0..31.
- R3: A valid command issues exactly four line reads, in order, at `cmd_addr`, `+64`, `+128` and `+192`. In a returned line, the word at offset 8*j from the request address sits in bits [64j+63:64j].
- R4: The sum wraps modulo 2^64, and an overflow sets no flag (`rsp_err` stays 0).
- R5: If `cmd_addr[2:0]` is nonzero, the response has `rsp_err`=1 and `rsp_sum`=0, and no memory read is issued.
- R6: `rsp_tag` equals the `cmd_tag` of the command it answers.
- R7: Each command produces exactly one response. `cmd_ready` is 0 from acceptance until that response is taken. While `rsp_ready` is low, `rsp_valid`, `rsp_sum`, `rsp_tag` and `rsp_err` hold steady.
- R8: The result does not depend on how many stall cycles come before `mem_req_ready` or before `mem_rsp_valid`.
- R9: While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept a command |
| cmd_addr | input | 32 | Byte address of the first quadword |
| cmd_tag | input | 8 | Tag returned with the response |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken by the consumer |
| rsp_sum | output | 64 | Wrapped 64-bit total |
| rsp_tag | output | 8 | Tag echoed from the command |
| rsp_err | output | 1 | Misaligned address; sum forced to zero |
| mem_req_valid | output | 1 | Line read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the line's first word |
| mem_rsp_valid | input | 1 | One-cycle pulse carrying line data |
| mem_rsp_data | input | 512 | Eight quadwords, lowest address in the low bits |

## Verification
The hardest case to reach is a line that arrives while the previous partial sum is still being folded in, mixed with request stalls. A wrong pass or slot index in that case silently moves a word from one half into the other. The bench sweeps every combination of request and response stall length across lines and commands. It uses word patterns whose per-index values differ, so a misplaced or repeated word changes the total. An all-ones pattern and a top-bit pattern force the modulo wrap. All eight low-address offsets are swept to cover the error path.

// File: rtl/sumred_pkg.sv
package sumred_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_SUM,
    ST_RESP
  } sumred_state_t;
endpackage

// File: rtl/sumred_tree.sv
module sumred_tree #(
  parameter int W = 64,
  parameter int N = 16
) (
  input  logic [N*W-1:0] leaves,
  output logic [W-1:0]   total
);
  // Heap-ordered nodes: node[k] = node[2k] + node[2k+1], leaves at N..2N-1
  logic [W-1:0] node [1:2*N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign node[N+i] = leaves[i*W +: W];
  end
  for (genvar k = N-1; k >= 1; k--) begin : g_node
    assign node[k] = node[2*k] + node[2*k+1];
  end

  assign total = node[1];
endmodule

// File: rtl/sumred_passbuf.sv
module sumred_passbuf #(
  parameter int W      = 64,
  parameter int WORDS  = 8,
  parameter int SLOTS  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [WORDS*W-1:0]      wr_line,
  output logic [SLOTS*WORDS*W-1:0] pass_words
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [WORDS*W-1:0] line_q;
    always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_slot) == s)) line_q <= wr_line;
    end
    assign pass_words[s*WORDS*W +: WORDS*W] = line_q;
  end
endmodule

// File: rtl/sumred_top.sv
module sumred_top
  import sumred_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 8,
  parameter int ELEM_W     = 64,
  parameter int ELEMS      = 32,
  parameter int TREE_N     = 16,
  parameter int LINE_ELEMS = 8,
  localparam int LINE_W    = LINE_ELEMS * ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ELEM_W-1:0] rsp_sum,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  localparam int LINES      = ELEMS / LINE_ELEMS;
  localparam int SLOTS      = TREE_N / LINE_ELEMS;
  localparam int LINE_CW    = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int ELEM_BYTES = ELEM_W / 8;
  localparam int ALIGN_W    = $clog2(ELEM_BYTES);
  localparam int LINE_BYTES = LINE_ELEMS * ELEM_BYTES;

  sumred_state_t state_q;
  logic [ADDR_W-1:0]  base_q;
  logic [LINE_CW-1:0] line_q;
  logic [ELEM_W-1:0]  acc_q;
  logic [ELEM_W-1:0]  sum_q;
  logic [TAG_W-1:0]   tag_q;
  logic               err_q;

  logic [SLOT_W-1:0]         slot;
  logic                      slot_last;
  logic                      line_last;
  logic                      cap;
  logic [TREE_N*ELEM_W-1:0]  pass_words;
  logic [ELEM_W-1:0]         pass_sum;

  assign slot      = SLOT_W'(int'(line_q) % SLOTS);
  assign slot_last = (int'(slot) == SLOTS - 1);
  assign line_last = (int'(line_q) == LINES - 1);
  assign cap       = (state_q == ST_WAIT) && mem_rsp_valid;

  sumred_passbuf #(
    .W(ELEM_W), .WORDS(LINE_ELEMS), .SLOTS(SLOTS)
  ) u_buf (
    .clk(clk), .wr_en(cap), .wr_slot(slot),
    .wr_line(mem_rsp_data), .pass_words(pass_words)
  );

  sumred_tree #(.W(ELEM_W), .N(TREE_N)) u_tree (
    .leaves(pass_words), .total(pass_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      line_q  <= '0;
      acc_q   <= '0;
      sum_q   <= '0;
      tag_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid) begin
          base_q <= cmd_addr;
          tag_q  <= cmd_tag;
          line_q <= '0;
          acc_q  <= '0;
          if (cmd_addr[ALIGN_W-1:0] != '0) begin
            err_q   <= 1'b1;
            sum_q   <= '0;
            state_q <= ST_RESP;
          end else begin
            err_q   <= 1'b0;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (slot_last) state_q <= ST_SUM;
          else begin
            line_q  <= line_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_SUM: begin
          acc_q <= acc_q + pass_sum;
          if (line_last) begin
            sum_q   <= acc_q + pass_sum;
            state_q <= ST_RESP;
          end else begin
            line_q  <= line_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_sum       = sum_q;
  assign rsp_tag       = tag_q;
  assign rsp_err       = err_q;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = base_q + ADDR_W'(int'(line_q) * LINE_BYTES);

  // R7: a pending response holds until taken
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_sum) && $stable(rsp_tag) && $stable(rsp_err));
  // R7: no new command while a response is outstanding
  assert_busy_no_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready);
  // R5: error responses carry a zero sum
  assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_sum == '0);
  // R9: memory request held with stable address until accepted
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3: no memory request overlaps a response
  assert_no_req_in_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);
endmodule

// File: tb/tb_sumred_top.sv
module tb_sumred_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, rsp_valid, rsp_ready = 0, rsp_err;
  logic [31:0] cmd_addr = 0, mem_req_addr;
  logic [7:0]  cmd_tag = 0, rsp_tag;
  logic [63:0] rsp_sum;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [511:0] mem_rsp_data = '0;

  sumred_top dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_tag(cmd_tag), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_sum(rsp_sum), .rsp_tag(rsp_tag),
    .rsp_err(rsp_err), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int errors = 0, checks = 0;
  int pat = 0, stall_seed = 0, reads = 0;
  logic [31:0] cur_base = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word(input logic [31:0] a, input int p);
    case (p)
      0: word = {32'h0, a} * 64'h9E37_79B9_7F4A_7C15 + 64'd17;
      1: word = 64'hFFFF_FFFF_FFFF_FFFF;
      default: word = 64'h8000_0000_0000_0000 | {32'h0, a};
    endcase
  endfunction

  function automatic logic [63:0] expect_sum(input logic [31:0] a, input int p);
    logic [63:0] s = 0;
    for (int i = 0; i < 32; i++) s += word(a + 32'(8*i), p);
    return s;
  endfunction

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0;
      mem_req_ready = 0;
      if (mem_req_valid) begin
        logic [31:0] a;
        int rs, ds;
        rs = (stall_seed + reads) % 4;
        ds = (stall_seed / 4 + 2*reads) % 5;
        repeat (rs) @(negedge clk);
        a = mem_req_addr;
        // R3: line addresses in order
        chk(a == cur_base + 32'(64*reads), "R3 line addr", {32'h0, a}, {32'h0, cur_base + 32'(64*reads)});
        mem_req_ready = 1;
        reads++;
        @(negedge clk);
        mem_req_ready = 0;
        repeat (ds) @(negedge clk);
        for (int j = 0; j < 8; j++) mem_rsp_data[64*j +: 64] = word(a + 32'(8*j), pat);
        mem_rsp_valid = 1;
      end
    end
  end

  task automatic run_cmd(input logic [31:0] a, input logic [7:0] tag, input int p, input int hold);
    logic [63:0] exp;
    bit mis;
    int guard;
    mis = (a[2:0] != 0);
    exp = mis ? 64'h0 : expect_sum(a, p);
    pat = p; cur_base = a; reads = 0;
    cmd_addr = a; cmd_tag = tag; cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    guard = 0;
    while (!rsp_valid && guard < 500) begin
      if (cmd_ready) chk(0, "R7 cmd_ready while busy", 1, 0);
      @(negedge clk); guard++;
    end
    chk(rsp_valid, "R7 response present", {63'h0, rsp_valid}, 1);
    if (mis) begin
      chk(rsp_err == 1 && rsp_sum == 0, "R5 misaligned error", rsp_sum, 0);
      chk(reads == 0, "R5 no memory read", reads, 0);
    end else begin
      chk(rsp_sum == exp, (p == 0) ? "R2 sum" : "R4 wrapped sum", rsp_sum, exp);
      chk(rsp_err == 0, "R4 no error flag", {63'h0, rsp_err}, 0);
      chk(reads == 4, "R3 four line reads", reads, 4);
    end
    chk(rsp_tag == tag, "R6 tag echo", {56'h0, rsp_tag}, {56'h0, tag});
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_sum == exp && rsp_tag == tag, "R7 held response", rsp_sum, exp);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && cmd_ready, "R7 single response", {63'h0, rsp_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {61'h0, cmd_ready, rsp_valid, mem_req_valid}, 64'h4);
    for (int p = 0; p < 3; p++)
      for (int off = 0; off < 8; off++) begin
        stall_seed = p * 8 + off;
        run_cmd(32'h0000_1000 + 32'(off * 8 + p * 256), 8'(p * 16 + off), p, off % 3);
      end
    for (int o = 1; o < 8; o++) begin
      stall_seed = o;
      run_cmd(32'h0000_2000 + 32'(o), 8'(8'hA0 + o), 0, 1);
    end
    // R8: same command under every stall mix gives the same sum
    for (int s = 0; s < 20; s++) begin
      stall_seed = s;
      run_cmd(32'h0000_3048, 8'(s), 0, 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule